// File: doc/BRIEF.md
# Resolution-Programmable Conversion Sequencer

This block paces the temperature conversions of a digital thermometer. A shared timer pulse (`tick_en`) advances a counter. Each conversion lasts a base number of ticks, doubled once for every resolution step above the coarsest. When a conversion finishes, the block takes the 12-bit sample on `raw_sample`, which stands in for the sensor converter, and clears the bits below the active resolution. It places the result in the upper bits of a 16-bit two's complement temperature word and pulses `done_stb` for one cycle to the thermostat comparator.

The state machine has two states. In `ST_CONVERT` a conversion is timing. In `ST_STANDBY` the block is idle with its last result held. There are three transitions:
- *restart*: `ST_CONVERT` to `ST_CONVERT`, when a conversion ends while `shutdown` is low.
- *park*: `ST_CONVERT` to `ST_STANDBY`, when a conversion ends while `shutdown` is high.
- *wake*: `ST_STANDBY` to `ST_CONVERT`, on the first clock edge that sees `shutdown` low.

`res_sel` is captured only when a conversion starts. Reset starts a 9-bit conversion at once.

Top module: `therm_conv_sched`

## Requirements
- R1: After reset `temp_word` is 0, `done_stb` is 0 and `converting` is 1. The first conversion uses the 9-bit length and runs without any start command.
- R2: A conversion lasts `BASE_TICKS << r` clock edges that have `tick_en` high, where r is the captured resolution code. Edges with `tick_en` low do not advance it.
- R3: While `shutdown` is low, the next conversion starts on the same edge that ends the previous one. Consecutive `done_stb` pulses are exactly one conversion length apart.
- R4: Resolution codes 0, 1, 2 and 3 mean 9, 10, 11 and 12 bits. On completion `temp_word[15:4]` takes `raw_sample` as it is at the completing edge, with its lowest 3-r bits forced to 0, and `temp_word[3:0]` is 0.
- R5: `temp_word` holds the last completed result and changes only on an edge that ends a conversion.
- R6: `done_stb` is high for exactly one cycle, in the same cycle in which the new `temp_word` first appears.
- R7: Raising `shutdown` during a conversion lets that conversion finish and store its result. The block then parks in `ST_STANDBY`, with `converting` low and no further `done_stb` while `shutdown` stays high.
- R8: In `ST_STANDBY`, the first edge that sees `shutdown` low enters `ST_CONVERT` with the timer at zero. The result therefore arrives `(BASE_TICKS << r) + 1` ticking edges after that edge's cycle.
- R9: `res_sel` is sampled only when a conversion starts. A change during a conversion alters neither its length nor its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer pulse; one conversion step per high cycle |
| res_sel | input | 2 | Resolution code, 0 = 9 bits up to 3 = 12 bits |
| shutdown | input | 1 | High requests standby after the current conversion |
| raw_sample | input | 12 | Sensor sample in two's complement, 1/16 degree per LSB |
| temp_word | output | 16 | Last completed result, left-justified, with low bits zero |
| done_stb | output | 1 | One-cycle pulse when `temp_word` is updated |
| converting | output | 1 | High while in `ST_CONVERT` |

## Verification
A timer that counts wrong, or a resolution captured at the wrong moment, moves `done_stb` away from its expected cycle. It is seen at the first completion after the fault, because the bench measures the edges between each start and each strobe. A wrong mask shows in the low bits of the very next `temp_word`. A state register stuck in the wrong state shows within one conversion length: either a strobe arrives while parked, or `converting` stays high after a shutdown completes.

// File: rtl/therm_seq_pkg.sv
package therm_seq_pkg;

    typedef enum logic [0:0] {
        ST_CONVERT = 1'b0,
        ST_STANDBY = 1'b1
    } seq_state_t;

endpackage

// File: rtl/conv_tick_timer.sv
module conv_tick_timer #(
    parameter int BASE_TICKS = 1000,
    parameter int RES_W      = 2,
    parameter int CNT_W      = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [RES_W-1:0] res_i,
    output logic             finish_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // Conversion length doubles per resolution step.
    always_comb begin
        lim = CNT_W'(BASE_TICKS) << res_i;
    end

    always_comb begin
        finish_o = run_i && tick_i && (cnt_q == (lim - CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (finish_o) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 16,
    parameter int RES_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                finish_i,
    input  logic [RES_W-1:0]    res_i,
    input  logic [SAMPLE_W-1:0] raw_i,
    output logic [WORD_W-1:0]   word_o,
    output logic                done_o
);

    localparam int MAX_DROP = (1 << RES_W) - 1;
    localparam int PAD_W    = WORD_W - SAMPLE_W;

    logic [RES_W:0]        drop;
    logic [SAMPLE_W-1:0]   kept;
    logic [WORD_W-1:0]     word_q;
    logic                  done_q;

    always_comb begin
        drop = (RES_W+1)'(MAX_DROP) - {1'b0, res_i};
    end

    // Clear the sample bits finer than the active resolution.
    for (genvar i = 0; i < SAMPLE_W; i++) begin : g_keep
        assign kept[i] = (i >= int'(drop)) ? raw_i[i] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish_i;
            if (finish_i) begin
                word_q <= {kept, {PAD_W{1'b0}}};
            end
        end
    end

    assign word_o = word_q;
    assign done_o = done_q;

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(word_q) |-> done_q);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (word_q[PAD_W-1:0] == '0));

endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
    import therm_seq_pkg::*;
#(
    parameter int RES_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shutdown_i,
    input  logic             finish_i,
    input  logic [RES_W-1:0] res_sel_i,
    output logic [RES_W-1:0] res_o,
    output logic             run_o
);

    seq_state_t       state_q, state_d;
    logic [RES_W-1:0] res_q;
    logic             start;

    // State register and captured resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CONVERT;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                res_q <= res_sel_i;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        run_o   = 1'b0;
        unique case (state_q)
            ST_CONVERT: begin
                run_o = 1'b1;
                if (finish_i) begin
                    if (shutdown_i) begin
                        state_d = ST_STANDBY;      // park
                    end else begin
                        start   = 1'b1;            // restart
                    end
                end
            end
            ST_STANDBY: begin
                if (!shutdown_i) begin
                    state_d = ST_CONVERT;          // wake
                    start   = 1'b1;
                end
            end
            default: state_d = ST_CONVERT;
        endcase
    end

    assign res_o = res_q;

    // R9
    res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !finish_i) |=> $stable(res_q));

    // R7
    no_finish_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY) |-> !finish_i);

endmodule

// File: rtl/therm_conv_sched.sv
module therm_conv_sched #(
    parameter int BASE_TICKS = 1000,
    parameter int SAMPLE_W   = 12,
    parameter int WORD_W     = 16,
    parameter int RES_W      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [RES_W-1:0]    res_sel,
    input  logic                shutdown,
    input  logic [SAMPLE_W-1:0] raw_sample,
    output logic [WORD_W-1:0]   temp_word,
    output logic                done_stb,
    output logic                converting
);

    localparam int MAX_RES = (1 << RES_W) - 1;
    localparam int CNT_W   = $clog2((BASE_TICKS << MAX_RES) + 1);

    logic             run;
    logic             finish;
    logic [RES_W-1:0] res_act;

    conv_seq_fsm #(
        .RES_W (RES_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .shutdown_i (shutdown),
        .finish_i   (finish),
        .res_sel_i  (res_sel),
        .res_o      (res_act),
        .run_o      (run)
    );

    conv_tick_timer #(
        .BASE_TICKS (BASE_TICKS),
        .RES_W      (RES_W),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (tick_en),
        .res_i    (res_act),
        .finish_o (finish)
    );

    conv_result_reg #(
        .SAMPLE_W (SAMPLE_W),
        .WORD_W   (WORD_W),
        .RES_W    (RES_W)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .finish_i (finish),
        .res_i    (res_act),
        .raw_i    (raw_sample),
        .word_o   (temp_word),
        .done_o   (done_stb)
    );

    assign converting = run;

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb && !$past(shutdown)) |-> converting);

    // R7
    parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!converting && shutdown) |=> !done_stb);

endmodule

// File: tb/therm_conv_sched_tb.sv
module therm_conv_sched_tb;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic [1:0]  res_sel = 2'd0;
    logic        shutdown = 1'b0;
    logic [11:0] raw_sample = 12'h191;
    logic [15:0] temp_word;
    logic        done_stb;
    logic        converting;

    int checks = 0;
    int errors = 0;
    int gap_cnt = 0;
    bit finished = 1'b0;

    logic [15:0] exp_word_q[$];
    int          exp_gap_q[$];
    string       exp_tag_q[$];

    always #5 clk = ~clk;

    therm_conv_sched #(.BASE_TICKS(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .res_sel    (res_sel),
        .shutdown   (shutdown),
        .raw_sample (raw_sample),
        .temp_word  (temp_word),
        .done_stb   (done_stb),
        .converting (converting)
    );

    function automatic logic [15:0] exp_word(logic [11:0] raw, int r);
        return {raw, 4'h0} & (16'hFFFF << (7 - r));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [15:0] w, int gap, string tag);
        exp_word_q.push_back(w);
        exp_gap_q.push_back(gap);
        exp_tag_q.push_back(tag);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_stb);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Gap counter: clock edges since the last strobe or start mark.
    always @(posedge clk) gap_cnt++;

    // Monitor: compare each completion against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done_stb) begin
            if (exp_word_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R7 actual=unexpected strobe expected=none");
            end else begin
                string tag;
                tag = exp_tag_q.pop_front();
                check({tag, "/R4 word"}, 32'(temp_word), 32'(exp_word_q.pop_front()));
                check({tag, "/R2 gap"}, 32'(gap_cnt), 32'(exp_gap_q.pop_front()));
            end
            gap_cnt = 0;
        end
    end

    // Single conversion from standby, with optional tick stall (R8, R9, R2).
    task automatic one_shot(int r, logic [11:0] raw, int stall);
        @(negedge clk);
        raw_sample = raw;
        res_sel    = 2'(r);
        push(exp_word(raw, r), (N << r) + 1 + stall, "R8");
        gap_cnt  = 0;
        shutdown = 1'b0;
        @(negedge clk);
        shutdown = 1'b1;
        res_sel  = ~2'(r);                      // R9: ignored mid-conversion
        check("R8 converting", 32'(converting), 32'd1);
        if (stall > 0) begin
            tick_en = 1'b0;
            repeat (stall) @(negedge clk);
            tick_en = 1'b1;
        end
        wait_done();
        @(negedge clk);
        check("R7 parked", 32'(converting), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 word", 32'(temp_word), 32'h0);
        check("R1 done", 32'(done_stb), 32'd0);
        check("R1 converting", 32'(converting), 32'd1);

        // Continuous operation, 9-bit first conversion.
        push(exp_word(12'h0A2, 0), N, "R1");
        rst_n   = 1'b1;
        gap_cnt = 0;
        @(negedge clk);
        raw_sample = 12'h0A2;                   // value at completion counts
        @(negedge clk);
        res_sel = 2'd2;                         // R9: applies to next conversion
        check("R5 hold", 32'(temp_word), 32'h0);
        wait_done();

        raw_sample = 12'hF5E;
        push(exp_word(12'hF5E, 2), N << 2, "R3");
        shutdown = 1'b1;                        // R7: finish this one, then park
        repeat (2) @(negedge clk);
        check("R5 hold", 32'(temp_word), 32'(exp_word(12'h0A2, 0)));
        check("R3 converting", 32'(converting), 32'd1);
        wait_done();
        repeat (3 * (N << 3)) @(negedge clk);
        check("R7 parked", 32'(converting), 32'd0);
        check("R7 word kept", 32'(temp_word), 32'(exp_word(12'hF5E, 2)));

        // Single conversions at every resolution.
        one_shot(0, 12'h800, 0);
        one_shot(1, 12'hFFF, 0);
        one_shot(2, 12'h555, 0);
        one_shot(3, 12'hAAB, 0);
        one_shot(3, 12'h191, 5);
        one_shot(0, 12'hC90, 3);

        repeat (N << 4) @(negedge clk);
        check("R7 scoreboard empty", 32'(exp_word_q.size()), 32'd0);
        finish_run();
    end

endmodule